// File: doc/BRIEF.md
# Programmable video timing generator

This block builds the raster control signals for a video pipeline: horizontal sync, vertical sync, horizontal blank, vertical blank and active video. Two counters track the pixel position within a line and the line within a frame. They advance only on cycles where the pixel-clock enable is high, so the block runs on a fast system clock and follows a slower pixel rate.

Software programs the frame geometry through a plain word-addressed write port. The geometry covers the total line and frame sizes, the active area, the horizontal sync window and the vertical sync lines. It also covers the pixel offsets within a line at which vertical sync and vertical blank change, and a polarity for each output. These writes go into a shadow set. The generator uses them only after a commit through the control register. While the generator runs, the commit takes effect at the next frame start. While it is stopped, the commit takes effect at once.

Two sticky status flags record the onset of vertical blank and the onset of active video. Each flag can be routed to a single interrupt line.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset every timing output is low (all polarities reset to active-high, generator stopped), irq is low and the status register (word 1) reads 0.
- R2: Horizontal blank is active while the pixel count is at or above the active pixel count (word 6 bits 12:0). Active video is active only while the pixel count is below that value and the line count is below the active line count (word 6 bits 28:16).
- R3: Horizontal sync is active for sync-start <= pixel < sync-end. The start is in word 7 bits 12:0 and the end is in bits 28:16.
- R4: Position is compared as (line, pixel) pairs. Vertical sync is active from the pair (start line = word 8 bits 12:0, start offset = word 9 bits 12:0). It stays active up to, but not including, the pair (end line = word 8 bits 28:16, end offset = word 9 bits 28:16).
- R5: Vertical blank is active from the pair (active line count, word 10 bits 12:0) to the end of the frame. It is also active in line 0 for pixels below word 10 bits 28:16.
- R6: Each output has a polarity bit in word 3: vertical blank bit 0, horizontal blank bit 1, vertical sync bit 2, horizontal sync bit 3, active video bit 4. A set bit gives an active-high output and a clear bit gives an active-low output.
- R7: Timing and polarity writes take effect only after a commit, which is a write of word 0 with bit 1 set. While the generator runs, the new set first applies to pixel 0 of the next frame. While it is stopped, the new set applies from the commit write.
- R8: Word 0 bit 2 enables the generator. One cycle after the enabling write, the outputs show pixel 0 of line 0 and then advance one pixel per enabled cycle. Writing 0 to word 0 drives every output to its inactive level one cycle later and returns the counters to the frame start.
- R9: While the pixel-clock enable is low, the counters and the outputs hold.
- R10: Status word 1 bit 12 is set at the onset of vertical blank and bit 13 at the onset of active video. Both bits are sticky. Writing 1 to a bit clears it.
- R11: irq is high whenever a status bit is set and the matching bit of interrupt-enable word 2 (same positions) is set.
- R12: A read returns the last written value of the addressed shadow register on rd_data one cycle after rd_addr is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_ce | input | 1 | Pixel-clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_data | output | 32 | Read data, registered |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| hblank | output | 1 | Horizontal blank |
| vblank | output | 1 | Vertical blank |
| active | output | 1 | Active video |
| irq | output | 1 | Interrupt request |

## Verification
The timing outputs lag the counters by one register. The pixel shown one cycle after the enabling write is pixel 0, and pixel k appears k cycles later. The bench samples on the falling edge after each rising edge and computes the expected pixel from the number of edges since the write.

A commit issued mid-frame must leave the rest of that frame on the old geometry. The bench therefore switches its arithmetic model exactly at the frame length. Status bits rise on the same edge that makes the output active, and irq follows in that cycle. Read data is checked one edge after the address is presented.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int TW   = 13;
  localparam int NSIG = 5;

  // signal index, equal to its polarity bit position
  localparam int S_VB = 0;
  localparam int S_HB = 1;
  localparam int S_VS = 2;
  localparam int S_HS = 3;
  localparam int S_AV = 4;

  // word addresses
  localparam int A_CTRL  = 0;
  localparam int A_STAT  = 1;
  localparam int A_IEN   = 2;
  localparam int A_POL   = 3;
  localparam int A_HSIZE = 4;
  localparam int A_VSIZE = 5;
  localparam int A_ACT   = 6;
  localparam int A_HSYNC = 7;
  localparam int A_VSL   = 8;
  localparam int A_VSP   = 9;
  localparam int A_VBP   = 10;

  localparam int CTRL_COMMIT = 1;
  localparam int CTRL_EN     = 2;
  localparam int ST_VB       = 12;
  localparam int ST_AV       = 13;

  typedef struct packed {
    logic [TW-1:0]   hsize;
    logic [TW-1:0]   vsize;
    logic [TW-1:0]   act_h;
    logic [TW-1:0]   act_v;
    logic [TW-1:0]   hs_start;
    logic [TW-1:0]   hs_end;
    logic [TW-1:0]   vs_start_l;
    logic [TW-1:0]   vs_end_l;
    logic [TW-1:0]   vs_start_p;
    logic [TW-1:0]   vs_end_p;
    logic [TW-1:0]   vb_start_p;
    logic [TW-1:0]   vb_end_p;
    logic [NSIG-1:0] pol;
  } timing_t;

  localparam timing_t TIMING_RST = '{pol: {NSIG{1'b1}}, default: '0};
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              frame_end,
  input  logic [1:0]        onset,
  output logic [31:0]       rd_data,
  output timing_t           work,
  output logic              en,
  output logic [1:0]        stat,
  output logic              irq
);
  timing_t    shadow;
  logic       pending;
  logic [1:0] ien;
  logic       commit_wr;
  logic       load;
  logic [1:0] clr;

  assign commit_wr = wr_en && (wr_addr == ADDR_W'(A_CTRL)) && wr_data[CTRL_COMMIT];
  // stopped: load at once; running: load on the edge that wraps to frame start
  assign load = (commit_wr || pending) && (!en || frame_end);
  assign clr  = (wr_en && wr_addr == ADDR_W'(A_STAT)) ? {wr_data[ST_AV], wr_data[ST_VB]} : 2'b00;
  assign irq  = |(stat & ien);

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow  <= TIMING_RST;
      work    <= TIMING_RST;
      pending <= 1'b0;
      en      <= 1'b0;
      stat    <= '0;
      ien     <= '0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          ADDR_W'(A_CTRL):  en <= wr_data[CTRL_EN];
          ADDR_W'(A_IEN):   ien <= {wr_data[ST_AV], wr_data[ST_VB]};
          ADDR_W'(A_POL):   shadow.pol <= wr_data[NSIG-1:0];
          ADDR_W'(A_HSIZE): shadow.hsize <= wr_data[TW-1:0];
          ADDR_W'(A_VSIZE): shadow.vsize <= wr_data[TW-1:0];
          ADDR_W'(A_ACT):   begin shadow.act_h <= wr_data[TW-1:0];      shadow.act_v <= wr_data[16+:TW];    end
          ADDR_W'(A_HSYNC): begin shadow.hs_start <= wr_data[TW-1:0];   shadow.hs_end <= wr_data[16+:TW];   end
          ADDR_W'(A_VSL):   begin shadow.vs_start_l <= wr_data[TW-1:0]; shadow.vs_end_l <= wr_data[16+:TW]; end
          ADDR_W'(A_VSP):   begin shadow.vs_start_p <= wr_data[TW-1:0]; shadow.vs_end_p <= wr_data[16+:TW]; end
          ADDR_W'(A_VBP):   begin shadow.vb_start_p <= wr_data[TW-1:0]; shadow.vb_end_p <= wr_data[16+:TW]; end
          default: ;
        endcase
      end
      pending <= (commit_wr || pending) && !load;
      if (load) work <= shadow;
      stat <= (stat & ~clr) | onset;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      rd_data <= '0;
      case (rd_addr)
        ADDR_W'(A_CTRL):  rd_data[CTRL_EN] <= en;
        ADDR_W'(A_STAT):  begin rd_data[ST_VB] <= stat[0]; rd_data[ST_AV] <= stat[1]; end
        ADDR_W'(A_IEN):   begin rd_data[ST_VB] <= ien[0];  rd_data[ST_AV] <= ien[1];  end
        ADDR_W'(A_POL):   rd_data[NSIG-1:0] <= shadow.pol;
        ADDR_W'(A_HSIZE): rd_data[TW-1:0] <= shadow.hsize;
        ADDR_W'(A_VSIZE): rd_data[TW-1:0] <= shadow.vsize;
        ADDR_W'(A_ACT):   begin rd_data[TW-1:0] <= shadow.act_h;      rd_data[16+:TW] <= shadow.act_v;    end
        ADDR_W'(A_HSYNC): begin rd_data[TW-1:0] <= shadow.hs_start;   rd_data[16+:TW] <= shadow.hs_end;   end
        ADDR_W'(A_VSL):   begin rd_data[TW-1:0] <= shadow.vs_start_l; rd_data[16+:TW] <= shadow.vs_end_l; end
        ADDR_W'(A_VSP):   begin rd_data[TW-1:0] <= shadow.vs_start_p; rd_data[16+:TW] <= shadow.vs_end_p; end
        ADDR_W'(A_VBP):   begin rd_data[TW-1:0] <= shadow.vb_start_p; rd_data[16+:TW] <= shadow.vb_end_p; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vtg_counter.sv
module vtg_counter #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         ce,
  input  logic [W-1:0] hsize,
  input  logic [W-1:0] vsize,
  output logic [W-1:0] h,
  output logic [W-1:0] v,
  output logic         frame_end
);
  logic h_last, v_last;

  // widened compare so a size of 0 cannot underflow
  assign h_last    = ({1'b0, h} + 1'b1) >= {1'b0, hsize};
  assign v_last    = ({1'b0, v} + 1'b1) >= {1'b0, vsize};
  assign frame_end = en && ce && h_last && v_last;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      h <= '0;
      v <= '0;
    end else if (ce) begin
      if (h_last) begin
        h <= '0;
        v <= v_last ? '0 : v + 1'b1;
      end else begin
        h <= h + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vtg_decode.sv
module vtg_decode
  import vtg_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [TW-1:0]   h,
  input  logic [TW-1:0]   v,
  input  timing_t         t,
  output logic [NSIG-1:0] pins,
  output logic [NSIG-1:0] raw,
  output logic [NSIG-1:0] onset
);
  logic [NSIG-1:0] nxt;
  logic [2*TW-1:0] pos;

  assign pos = {v, h};

  always_comb begin
    nxt = '0;
    if (en) begin
      nxt[S_HB] = h >= t.act_h;
      nxt[S_AV] = (h < t.act_h) && (v < t.act_v);
      nxt[S_HS] = (h >= t.hs_start) && (h < t.hs_end);
      nxt[S_VS] = (pos >= {t.vs_start_l, t.vs_start_p}) && (pos < {t.vs_end_l, t.vs_end_p});
      nxt[S_VB] = (pos >= {t.act_v, t.vb_start_p}) || ((v == '0) && (h < t.vb_end_p));
    end
  end

  assign onset = nxt & ~raw;

  always_ff @(posedge clk) begin
    if (rst) raw <= '0;
    else     raw <= nxt;
  end

  for (genvar i = 0; i < NSIG; i++) begin : g_pol
    always_ff @(posedge clk) begin
      if (rst) pins[i] <= 1'b0;
      else     pins[i] <= nxt[i] ~^ t.pol[i];
    end
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import vtg_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_ce,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              hsync,
  output logic              vsync,
  output logic              hblank,
  output logic              vblank,
  output logic              active,
  output logic              irq
);
  timing_t         work;
  logic            en;
  logic [1:0]      stat;
  logic            frame_end;
  logic [TW-1:0]   hcnt, vcnt;
  logic [NSIG-1:0] pins, raw, onset;

  vtg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .frame_end(frame_end), .onset({onset[S_AV], onset[S_VB]}),
    .rd_data(rd_data), .work(work), .en(en), .stat(stat), .irq(irq)
  );

  vtg_counter #(.W(TW)) u_cnt (
    .clk(clk), .rst(rst), .en(en), .ce(pix_ce), .hsize(work.hsize), .vsize(work.vsize),
    .h(hcnt), .v(vcnt), .frame_end(frame_end)
  );

  vtg_decode u_dec (
    .clk(clk), .rst(rst), .en(en), .h(hcnt), .v(vcnt), .t(work),
    .pins(pins), .raw(raw), .onset(onset)
  );

  assign vblank = pins[S_VB];
  assign hblank = pins[S_HB];
  assign vsync  = pins[S_VS];
  assign hsync  = pins[S_HS];
  assign active = pins[S_AV];
endmodule

// File: rtl/vtg_chk.sv
module vtg_chk
  import vtg_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              pix_ce,
  input logic              en,
  input logic [TW-1:0]     hcnt,
  input logic [TW-1:0]     vcnt,
  input logic [TW-1:0]     hsize_w,
  input logic [NSIG-1:0]   raw,
  input logic [1:0]        stat,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data
);
  p_hcnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
    (en && hsize_w != '0) |-> (hcnt < hsize_w));

  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (raw == '0));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && !$past(pix_ce)) |-> (hcnt == $past(hcnt) && vcnt == $past(vcnt)));

  p_av_not_hb_r2: assert property (@(posedge clk) disable iff (rst)
    raw[S_AV] |-> !raw[S_HB]);

  p_sticky_vb_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(stat[0]) |-> $past(wr_en && wr_addr == ADDR_W'(A_STAT) && wr_data[ST_VB]));

  p_sticky_av_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(stat[1]) |-> $past(wr_en && wr_addr == ADDR_W'(A_STAT) && wr_data[ST_AV]));
endmodule

bind raster_timing_gen vtg_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .pix_ce(pix_ce), .en(en), .hcnt(hcnt), .vcnt(vcnt),
  .hsize_w(work.hsize), .raw(raw), .stat(stat), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data)
);

// File: tb/tb_raster_timing_gen.sv
module tb_raster_timing_gen;
  localparam int AW = 4;
  localparam int HS_A = 10, HS_B = 12, VS = 6, AH = 6, AV = 4;
  localparam int HSS = 7, HSE = 9, VSL = 4, VEL = 5, VSO_S = 3, VSO_E = 2, VBS = 2, VBE = 1;

  logic clk = 1'b0, rst = 1'b1, pix_ce = 1'b1, wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic hsync, vsync, hblank, vblank, active, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  raster_timing_gen #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .pix_ce(pix_ce), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .hsync(hsync),
    .vsync(vsync), .hblank(hblank), .vblank(vblank), .active(active), .irq(irq)
  );

  always #10 clk = ~clk;

  function automatic logic [4:0] exp_raw(int h, int v);
    logic [4:0] r;
    int pos;
    pos = v * 8192 + h;
    r[0] = (pos >= AV * 8192 + VBS) || (v == 0 && h < VBE);
    r[1] = h >= AH;
    r[2] = (pos >= VSL * 8192 + VSO_S) && (pos < VEL * 8192 + VSO_E);
    r[3] = (h >= HSS) && (h < HSE);
    r[4] = (h < AH) && (v < AV);
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic chk_pins(int h, int v, logic [4:0] pol, string extra);
    logic [4:0] got, exp;
    string tags [5];
    tags = '{"R5", "R2", "R4", "R3", "R2"};
    got = {active, hsync, vsync, hblank, vblank};
    exp = exp_raw(h, v) ~^ pol;
    for (int b = 0; b < 5; b++) begin
      checks++;
      if (got[b] !== exp[b]) begin
        errors++;
        $display("FAIL %s%s bit%0d at h=%0d v=%0d: got %0b expected %0b",
                 tags[b], extra, b, h, v, got[b], exp[b]);
      end
    end
  endtask

  task automatic wr(int addr, logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(addr); wr_data = data;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int addr, output logic [31:0] data);
    @(negedge clk);
    rd_addr = AW'(addr);
    @(posedge clk);
    @(negedge clk);
    data = rd_data;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [4:0] last;
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 pins", {27'b0, active, hsync, vsync, hblank, vblank}, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd(1, r);
    check("R1 status", r, 32'h0);

    wr(4, HS_A); wr(5, VS); wr(6, (AV << 16) | AH); wr(7, (HSE << 16) | HSS);
    wr(8, (VEL << 16) | VSL); wr(9, (VSO_E << 16) | VSO_S); wr(10, (VBE << 16) | VBS);
    wr(3, 32'h1F); wr(2, 0);
    rd(4, r);
    check("R12 hsize readback", r, HS_A);
    rd(7, r);
    check("R12 hsync readback", r, (HSE << 16) | HSS);
    wr(0, 32'h6);  // enable and commit while stopped (R8, R7)

    // sweep: frame 0 with HS_A, commit of HS_B mid-frame, then frames at HS_B
    for (int k = 0; k < 60 + 2 * 72; k++) begin
      int h, v, kk;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      if (k < 60) begin h = k % HS_A; v = k / HS_A; end
      else begin kk = (k - 60) % (HS_B * VS); h = kk % HS_B; v = kk / HS_B; end
      chk_pins(h, v, 5'h1F, (k < 60) ? " R8" : " R7");
      if (k == 20) begin wr_en = 1'b1; wr_addr = 4; wr_data = HS_B; end
      if (k == 21) begin wr_en = 1'b1; wr_addr = 0; wr_data = 32'h6; end
    end
    rd(4, r);
    check("R12 hsize shadow", r, HS_B);
    rd(0, r);
    check("R12 ctrl enable", r, 32'h4);

    // R9 hold while pix_ce low
    @(negedge clk);
    pix_ce = 1'b0;
    @(posedge clk);
    @(negedge clk);
    last = {active, hsync, vsync, hblank, vblank};
    for (int i = 0; i < 6; i++) begin
      @(posedge clk);
      @(negedge clk);
      check("R9 hold", {27'b0, active, hsync, vsync, hblank, vblank}, {27'b0, last});
    end
    pix_ce = 1'b1;

    // R8 stop
    wr(0, 0);
    @(posedge clk);
    @(negedge clk);
    check("R8 stopped idle", {27'b0, active, hsync, vsync, hblank, vblank}, 32'h0);

    // R6 active-low polarity committed while stopped (R7 immediate)
    wr(4, HS_A); wr(3, 0); wr(0, 32'h2);
    @(posedge clk);
    @(negedge clk);
    check("R6 idle active-low", {27'b0, active, hsync, vsync, hblank, vblank}, 32'h1F);

    // R10 clear, R11 enable on vblank bit
    wr(1, 32'h3000);
    rd(1, r);
    check("R10 cleared", r, 32'h0);
    wr(2, 32'h1000);
    check("R11 irq low before onset", {31'b0, irq}, 32'h0);
    wr(0, 32'h4);
    for (int k = 0; k < 60; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk_pins(k % HS_A, k / HS_A, 5'h00, " R6");
      if (k == 0) check("R11 irq on vblank onset", {31'b0, irq}, 32'h1);
    end
    rd(1, r);
    check("R10 sticky status", r, 32'h3000);
    wr(2, 32'h2000);
    check("R11 irq via active bit", {31'b0, irq}, 32'h1);
    wr(2, 0);
    check("R11 irq masked", {31'b0, irq}, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule